// File: doc/BRIEF.md
# Dual Simultaneous-Sampling Converter Sequencer

This block sits on the host side of a dual successive-approximation converter whose two cores sample together and return their results on two serial data lines that share one clock. A conversion is requested either by a one-cycle start pulse or by an internal rate timer. The sequencer pulls the active-low convert line low for a fixed number of cycles, waits for the converter's busy line to rise and then to fall, and then lowers chip select and clocks both data lines in parallel. The two words it gathers are sign-extended to 16 bits and presented together with a one-cycle valid pulse.

The block also drives the converter's channel-address pin and its two range-select pins. The converter latches the address when busy rises and uses it for the conversion that follows, so every result is tagged with the address captured one conversion earlier. Range and address updates from the host go first into shadow registers, and they reach the pins only where a change cannot disturb the analog settling ahead of a conversion. After any pin change, or after busy falls, the sequencer holds off the next convert edge for a full acquisition interval. If busy never completes, a timeout flags the fault and returns the sequencer to idle.

Top module: `dual_sar_sequencer`

## Requirements
- R1: A `start_req` pulse, or a rate-timer tick, drives `adc_cnv_n` low for exactly CNV_LOW clock cycles. A request that arrives while a conversion is running is held and served once the sequencer is idle again.
- R2: `adc_cs_n` goes low only after `adc_busy` has fallen, and never while busy is high. Each frame has exactly DATA_W falling edges of `adc_sclk`, which idles high. Both data lines are sampled on each falling edge, most significant bit first.
- R3: `smp_a` and `smp_b` carry the two's-complement words sign-extended to 16 bits, with bit DATA_W-1 copied into every upper bit. `smp_valid` is high for exactly one cycle per conversion.
- R4: `smp_chan` equals the level that `adc_addr` had at the rising edge of busy in the previous completed conversion. The first conversion after reset reports 0, whatever `adc_addr` shows.
- R5: A configuration write whose range field is 2'b11 leaves the range unchanged, and the address in the same write still takes effect. The range encodings are 2'b00 for ±10 V, 2'b01 for ±5 V and 2'b10 for 0 to 10 V.
- R6: The falling edge of `adc_cnv_n` comes at least ACQ_CYCLES cycles after the last fall of `adc_busy`, and at least ACQ_CYCLES cycles after the last change of `adc_range` or `adc_addr`.
- R7: A configuration write reaches the pins only while the sequencer is idle or while busy is high. The pins never change between a convert falling edge and the next rise of busy.
- R8: If busy fails to rise, or fails to fall, within BUSY_TIMEOUT cycles, `busy_err` pulses for one cycle. The sequencer then returns to idle with `adc_cnv_n` and `adc_cs_n` high, and it serves the next request normally.
- R9: With `rate_en` high, conversions are requested every `rate_period` cycles, so consecutive convert falling edges are exactly `rate_period` cycles apart as long as each conversion finishes within the period.
- R10: After reset, `adc_cnv_n`, `adc_cs_n` and `adc_sclk` are high, `adc_range` is 2'b00, `adc_addr` is 0, and `smp_valid` and `busy_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | One-cycle request for a conversion |
| rate_en | input | 1 | Enables the periodic conversion timer |
| rate_period | input | RATE_W | Timer period in clock cycles |
| cfg_wr | input | 1 | Loads the address and range shadow registers |
| cfg_addr | input | 1 | Requested channel-pair address |
| cfg_range | input | 2 | Requested input range code |
| adc_cnv_n | output | 1 | Active-low conversion start to the converter |
| adc_busy | input | 1 | Busy indication from the converter |
| adc_cs_n | output | 1 | Active-low chip select for readout |
| adc_sclk | output | 1 | Serial clock, idles high |
| adc_dout_a | input | 1 | Serial data from converter core A |
| adc_dout_b | input | 1 | Serial data from converter core B |
| adc_addr | output | 1 | Channel-address pin |
| adc_range | output | 2 | Range-select pins |
| smp_a | output | 16 | Sign-extended result of core A |
| smp_b | output | 16 | Sign-extended result of core B |
| smp_chan | output | 1 | Channel pair the results came from |
| smp_valid | output | 1 | One-cycle strobe marking new results |
| busy_err | output | 1 | One-cycle pulse when the busy handshake times out |

## Verification
The bench builds the block with DATA_W of 14, so two upper bits are filled by sign extension and both the most negative and the largest positive word can be forced. It uses a serial-clock divider of 2 to keep frames short. ACQ_CYCLES of 8 and CNV_LOW of 2 make the acquisition hold-off measurable against a converter model that takes 20 cycles per conversion. A BUSY_TIMEOUT of 64 lets a stalled-busy run expire quickly, and a rate period of 150 cycles is long enough that each conversion ends before the next tick, so the spacing between convert edges can be checked exactly.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_CONVST,
        SEQ_WAIT_RISE,
        SEQ_WAIT_FALL,
        SEQ_READ
    } seq_st_e;

    localparam int SMP_W = 16;
    localparam int LANES = 2;
    localparam logic [1:0] RANGE_BAD = 2'b11;

endpackage

// File: rtl/dsq_rate_tick.sv
module dsq_rate_tick #(
    parameter int RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [RATE_W-1:0] period,
    output logic              tick
);

    typedef struct packed {
        logic [RATE_W-1:0] cnt;
        logic              tick;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (!en) begin
            st_d.cnt = '0;
        end else if (({1'b0, st_q.cnt} + (RATE_W+1)'(1)) >= {1'b0, period}) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = st_q.tick;

endmodule

// File: rtl/dsq_cfg_shadow.sv
module dsq_cfg_shadow
    import dsq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic       addr_in,
    input  logic [1:0] range_in,
    input  logic       apply,
    output logic       addr_pin,
    output logic [1:0] range_pin,
    output logic       pending
);

    typedef struct packed {
        logic       sh_addr;
        logic [1:0] sh_range;
        logic       dirty;
        logic       pin_addr;
        logic [1:0] pin_range;
    } shadow_st_t;

    shadow_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // move the held request to the pins only when the sequencer allows it
        if (apply && st_q.dirty) begin
            st_d.pin_addr  = st_q.sh_addr;
            st_d.pin_range = st_q.sh_range;
            st_d.dirty     = 1'b0;
        end
        if (wr) begin
            st_d.sh_addr = addr_in;
            if (range_in != RANGE_BAD) st_d.sh_range = range_in;
            st_d.dirty = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_pin  = st_q.pin_addr;
    assign range_pin = st_q.pin_range;
    assign pending   = st_q.dirty;

endmodule

// File: rtl/dsq_serial_rx.sv
module dsq_serial_rx
    import dsq_pkg::*;
#(
    parameter int DATA_W  = 12,
    parameter int CLK_DIV = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         go,
    input  logic [LANES-1:0]             din,
    output logic                         cs_n,
    output logic                         sclk,
    output logic                         done,
    output logic [LANES-1:0][DATA_W-1:0] word
);

    localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam int BIT_W = $clog2(DATA_W + 1);

    typedef struct packed {
        logic                         active;
        logic                         cs_n;
        logic                         sclk;
        logic                         done;
        logic [DIV_W-1:0]             div;
        logic [BIT_W-1:0]             nbit;
        logic [LANES-1:0][DATA_W-1:0] sh;
    } rx_st_t;

    rx_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.active) begin
            if (go) begin
                st_d.active = 1'b1;
                st_d.cs_n   = 1'b0;
                st_d.sclk   = 1'b1;
                st_d.div    = '0;
                st_d.nbit   = '0;
            end
        end else if (st_q.div == DIV_W'(CLK_DIV - 1)) begin
            st_d.div = '0;
            if (st_q.sclk) begin
                // falling edge: take one bit from every lane, MSB first
                st_d.sclk = 1'b0;
                for (int l = 0; l < LANES; l++) begin
                    st_d.sh[l] = {st_q.sh[l][DATA_W-2:0], din[l]};
                end
                st_d.nbit = st_q.nbit + 1'b1;
            end else begin
                st_d.sclk = 1'b1;
                if (st_q.nbit == BIT_W'(DATA_W)) begin
                    st_d.active = 1'b0;
                    st_d.cs_n   = 1'b1;
                    st_d.done   = 1'b1;
                end
            end
        end else begin
            st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.cs_n <= 1'b1;
            st_q.sclk <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cs_n = st_q.cs_n;
    assign sclk = st_q.sclk;
    assign done = st_q.done;
    assign word = st_q.sh;

endmodule

// File: rtl/dual_sar_sequencer.sv
module dual_sar_sequencer
    import dsq_pkg::*;
#(
    parameter int DATA_W       = 12,
    parameter int CLK_DIV      = 4,
    parameter int ACQ_CYCLES   = 14,
    parameter int CNV_LOW      = 2,
    parameter int BUSY_TIMEOUT = 400,
    parameter int RATE_W       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              rate_en,
    input  logic [RATE_W-1:0] rate_period,
    input  logic              cfg_wr,
    input  logic              cfg_addr,
    input  logic [1:0]        cfg_range,
    output logic              adc_cnv_n,
    input  logic              adc_busy,
    output logic              adc_cs_n,
    output logic              adc_sclk,
    input  logic              adc_dout_a,
    input  logic              adc_dout_b,
    output logic              adc_addr,
    output logic [1:0]        adc_range,
    output logic [15:0]       smp_a,
    output logic [15:0]       smp_b,
    output logic              smp_chan,
    output logic              smp_valid,
    output logic              busy_err
);

    localparam int CNT_MAX = (BUSY_TIMEOUT > CNV_LOW) ? BUSY_TIMEOUT : CNV_LOW;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int ACQ_W   = $clog2(ACQ_CYCLES + 1);

    typedef struct packed {
        seq_st_e                     state;
        logic                        cnv_n;
        logic [CNT_W-1:0]            cnt;
        logic [ACQ_W-1:0]            acq;
        logic                        pend;
        logic                        cur_tag;
        logic                        lat_tag;
        logic [LANES-1:0][SMP_W-1:0] smp;
        logic                        chan;
        logic                        valid;
        logic                        err;
    } seq_st_t;

    seq_st_t st_d, st_q;

    logic                         tick;
    logic                         cfg_pend;
    logic                         cfg_apply;
    logic                         rx_go;
    logic                         rx_done;
    logic [LANES-1:0][DATA_W-1:0] rx_word;
    logic [LANES-1:0][SMP_W-1:0]  ext;

    dsq_rate_tick #(.RATE_W(RATE_W)) u_rate (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (rate_en),
        .period (rate_period),
        .tick   (tick)
    );

    dsq_cfg_shadow u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (cfg_wr),
        .addr_in   (cfg_addr),
        .range_in  (cfg_range),
        .apply     (cfg_apply),
        .addr_pin  (adc_addr),
        .range_pin (adc_range),
        .pending   (cfg_pend)
    );

    dsq_serial_rx #(.DATA_W(DATA_W), .CLK_DIV(CLK_DIV)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (rx_go),
        .din   ({adc_dout_b, adc_dout_a}),
        .cs_n  (adc_cs_n),
        .sclk  (adc_sclk),
        .done  (rx_done),
        .word  (rx_word)
    );

    // widen each lane to the output width with its sign bit
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        if (DATA_W < SMP_W) begin : g_ext
            assign ext[l] = {{(SMP_W-DATA_W){rx_word[l][DATA_W-1]}}, rx_word[l]};
        end else begin : g_full
            assign ext[l] = rx_word[l][SMP_W-1:0];
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.err   = 1'b0;
        cfg_apply  = 1'b0;
        rx_go      = 1'b0;

        if (st_q.acq != ACQ_W'(ACQ_CYCLES)) st_d.acq = st_q.acq + 1'b1;

        unique case (st_q.state)
            SEQ_IDLE: begin
                if (cfg_pend) begin
                    // pins move now, so the settling window starts over
                    cfg_apply = 1'b1;
                    st_d.acq  = '0;
                end else if (st_q.pend && st_q.acq == ACQ_W'(ACQ_CYCLES)) begin
                    st_d.state = SEQ_CONVST;
                    st_d.cnv_n = 1'b0;
                    st_d.cnt   = '0;
                    st_d.pend  = 1'b0;
                end
            end
            SEQ_CONVST: begin
                if (st_q.cnt == CNT_W'(CNV_LOW - 1)) begin
                    st_d.cnv_n = 1'b1;
                    st_d.state = SEQ_WAIT_RISE;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            SEQ_WAIT_RISE: begin
                if (adc_busy) begin
                    st_d.state   = SEQ_WAIT_FALL;
                    st_d.cnt     = '0;
                    st_d.cur_tag = st_q.lat_tag;
                    st_d.lat_tag = adc_addr;
                end else if (st_q.cnt == CNT_W'(BUSY_TIMEOUT - 1)) begin
                    st_d.err   = 1'b1;
                    st_d.state = SEQ_IDLE;
                    st_d.acq   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            SEQ_WAIT_FALL: begin
                cfg_apply = 1'b1;
                if (!adc_busy) begin
                    st_d.state = SEQ_READ;
                    st_d.acq   = '0;
                    rx_go      = 1'b1;
                end else if (st_q.cnt == CNT_W'(BUSY_TIMEOUT - 1)) begin
                    st_d.err   = 1'b1;
                    st_d.state = SEQ_IDLE;
                    st_d.acq   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            SEQ_READ: begin
                if (rx_done) begin
                    st_d.smp   = ext;
                    st_d.chan  = st_q.cur_tag;
                    st_d.valid = 1'b1;
                    st_d.state = SEQ_IDLE;
                end
            end
            default: st_d.state = SEQ_IDLE;
        endcase

        // requests raised during a conversion are held for the next one
        if (start_req || tick) st_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= SEQ_IDLE;
            st_q.cnv_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign adc_cnv_n = st_q.cnv_n;
    assign smp_a     = st_q.smp[0];
    assign smp_b     = st_q.smp[1];
    assign smp_chan  = st_q.chan;
    assign smp_valid = st_q.valid;
    assign busy_err  = st_q.err;

endmodule

// File: rtl/dsq_checker.sv
module dsq_checker #(
    parameter int ACQ_CYCLES = 14
) (
    input logic       clk,
    input logic       rst_n,
    input logic       adc_cnv_n,
    input logic       adc_busy,
    input logic       adc_cs_n,
    input logic       adc_sclk,
    input logic       adc_addr,
    input logic [1:0] adc_range,
    input logic       smp_valid,
    input logic       busy_err
);

    logic [15:0] since_busy;
    logic [15:0] since_cfg;
    logic [2:0]  pins_p;
    logic        cnv_p;
    logic        win;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_busy <= '0;
            since_cfg  <= '0;
            pins_p     <= '0;
            cnv_p      <= 1'b1;
            win        <= 1'b0;
        end else begin
            pins_p <= {adc_addr, adc_range};
            cnv_p  <= adc_cnv_n;
            if (adc_busy)                 since_busy <= '0;
            else if (since_busy != '1)    since_busy <= since_busy + 1'b1;
            if ({adc_addr, adc_range} != pins_p) since_cfg <= '0;
            else if (since_cfg != '1)            since_cfg <= since_cfg + 1'b1;
            if (win) win <= !(adc_busy || busy_err);
            else     win <= cnv_p && !adc_cnv_n;
        end
    end

    a_r5_range_legal: assert property (@(posedge clk) disable iff (!rst_n)
        adc_range != 2'b11);

    a_r6_acq_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cnv_n) |-> since_busy >= 16'(ACQ_CYCLES));

    a_r6_acq_after_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cnv_n) |-> since_cfg >= 16'(ACQ_CYCLES));

    a_r7_pins_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        win |-> $stable({adc_addr, adc_range}));

    a_r2_read_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_cs_n |-> !adc_busy);

    a_r2_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cs_n |-> adc_sclk);

    a_r3_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> !smp_valid);

    a_r8_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        busy_err |=> !busy_err);

endmodule

bind dual_sar_sequencer dsq_checker #(.ACQ_CYCLES(ACQ_CYCLES)) u_dsq_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .adc_cnv_n (adc_cnv_n),
    .adc_busy  (adc_busy),
    .adc_cs_n  (adc_cs_n),
    .adc_sclk  (adc_sclk),
    .adc_addr  (adc_addr),
    .adc_range (adc_range),
    .smp_valid (smp_valid),
    .busy_err  (busy_err)
);

// File: tb/test_dual_sar_sequencer.sv
module test_dual_sar_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 14;
    localparam int DIV        = 2;
    localparam int ACQ        = 8;
    localparam int CNVL       = 2;
    localparam int TMO        = 64;
    localparam int RW         = 16;
    localparam int CONV_CYC   = 20;
    localparam int RATE_P     = 150;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_req = 1'b0;
    logic          rate_en = 1'b0;
    logic [RW-1:0] rate_period = '0;
    logic          cfg_wr = 1'b0;
    logic          cfg_addr = 1'b0;
    logic [1:0]    cfg_range = 2'b00;
    logic          adc_cnv_n;
    logic          adc_busy = 1'b0;
    logic          adc_cs_n;
    logic          adc_sclk;
    logic          adc_dout_a = 1'b0;
    logic          adc_dout_b = 1'b0;
    logic          adc_addr;
    logic [1:0]    adc_range;
    logic [15:0]   smp_a;
    logic [15:0]   smp_b;
    logic          smp_chan;
    logic          smp_valid;
    logic          busy_err;

    int vectors = 0;
    int miscmp  = 0;

    // converter model state
    logic          hang = 1'b0;
    logic          use_fixed = 1'b0;
    logic [DW-1:0] fix_a = '0;
    logic [DW-1:0] fix_b = '0;
    logic [DW-1:0] word_a = '0;
    logic [DW-1:0] word_b = '0;
    logic [15:0]   exp_a = '0;
    logic [15:0]   exp_b = '0;
    logic          exp_tag = 1'b0;
    logic          model_lat = 1'b0;
    int            bit_ix = 0;

    // observation state
    int            got_valid = 0;
    logic          last_tag = 1'b0;
    int            nfall = 0;
    logic          frame_armed = 1'b0;
    int            cnv_falls = 0;
    logic          rate_chk = 1'b0;
    logic          have_prev = 1'b0;
    longint        last_fall = 0;
    int            err_seen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_sar_sequencer #(
        .DATA_W(DW), .CLK_DIV(DIV), .ACQ_CYCLES(ACQ), .CNV_LOW(CNVL),
        .BUSY_TIMEOUT(TMO), .RATE_W(RW)
    ) i_dual_sar_sequencer (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .rate_en(rate_en),
        .rate_period(rate_period), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_range(cfg_range), .adc_cnv_n(adc_cnv_n), .adc_busy(adc_busy),
        .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_dout_a(adc_dout_a),
        .adc_dout_b(adc_dout_b), .adc_addr(adc_addr), .adc_range(adc_range),
        .smp_a(smp_a), .smp_b(smp_b), .smp_chan(smp_chan),
        .smp_valid(smp_valid), .busy_err(busy_err)
    );

    function automatic logic [15:0] sext(input logic [DW-1:0] w);
        return {{(16-DW){w[DW-1]}}, w};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            miscmp++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    endtask

    // converter: busy after the convert edge, words chosen at busy rise
    initial begin
        forever begin
            @(negedge adc_cnv_n);
            if (!hang) begin
                @(posedge clk);
                #1;
                word_a   = use_fixed ? fix_a : DW'($urandom);
                word_b   = use_fixed ? fix_b : DW'($urandom);
                exp_a    = sext(word_a);
                exp_b    = sext(word_b);
                exp_tag  = model_lat;
                model_lat = adc_addr;
                adc_busy = 1'b1;
                repeat (CONV_CYC) @(posedge clk);
                #1 adc_busy = 1'b0;
            end
        end
    end

    initial begin
        forever begin
            @(negedge adc_cs_n);
            frame_armed = 1'b1;
            nfall  = 0;
            bit_ix = DW - 1;
            adc_dout_a = word_a[bit_ix];
            adc_dout_b = word_b[bit_ix];
        end
    end

    initial begin
        forever begin
            @(posedge adc_sclk);
            if (adc_cs_n == 1'b0 && bit_ix > 0) begin
                bit_ix--;
                adc_dout_a = word_a[bit_ix];
                adc_dout_b = word_b[bit_ix];
            end
        end
    end

    initial begin
        forever begin
            @(negedge adc_sclk);
            if (adc_cs_n == 1'b0) nfall++;
        end
    end

    initial begin
        forever begin
            @(posedge adc_cs_n);
            if (frame_armed) begin
                check(nfall == DW, "R2", "sclk falls per frame", nfall, DW);
                frame_armed = 1'b0;
            end
        end
    end

    // convert pulse width and rate spacing
    initial begin
        forever begin
            int w;
            @(negedge adc_cnv_n);
            cnv_falls++;
            if (rate_chk && have_prev)
                check(($time - last_fall) == RATE_P * CLK_PERIOD, "R9",
                      "convert spacing", ($time - last_fall) / CLK_PERIOD, RATE_P);
            last_fall = $time;
            have_prev = 1'b1;
            w = 0;
            forever begin
                @(negedge clk);
                if (adc_cnv_n) break;
                w++;
            end
            check(w == CNVL, "R1", "convert low width", w, CNVL);
        end
    end

    // per-cycle monitor: results, handshake order, settling and freeze window
    initial begin
        int   since_busy = 0;
        int   since_cfg  = 0;
        logic prev_cnv   = 1'b1;
        logic [2:0] prev_pins = 3'b000;
        logic win = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (smp_valid) begin
                    got_valid++;
                    last_tag = smp_chan;
                    check(smp_a == exp_a, "R3", "lane A sample", smp_a, exp_a);
                    check(smp_b == exp_b, "R3", "lane B sample", smp_b, exp_b);
                    check(smp_chan == exp_tag, "R4", "channel tag", smp_chan, exp_tag);
                end
                if (busy_err) err_seen++;
                if (!adc_cs_n && adc_busy) check(0, "R2", "cs low while busy", 1, 0);
                if (win && {adc_addr, adc_range} != prev_pins)
                    check(0, "R7", "pins moved before busy rise",
                          {adc_addr, adc_range}, prev_pins);
                if (prev_cnv && !adc_cnv_n) begin
                    check(since_busy >= ACQ, "R6", "cycles since busy fall", since_busy, ACQ);
                    check(since_cfg >= ACQ, "R6", "cycles since pin change", since_cfg, ACQ);
                    win = 1'b1;
                end
                if (win && (adc_busy || busy_err)) win = 1'b0;
                since_busy = adc_busy ? 0 : since_busy + 1;
                since_cfg  = ({adc_addr, adc_range} != prev_pins) ? 0 : since_cfg + 1;
                prev_cnv  = adc_cnv_n;
                prev_pins = {adc_addr, adc_range};
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "watchdog", "run did not finish", 0, 1);
        finish_run();
    end

    task automatic pulse_start();
        @(posedge clk); #1 start_req = 1'b1;
        @(posedge clk); #1 start_req = 1'b0;
    endtask

    task automatic cfg_write(input logic a, input logic [1:0] r);
        @(posedge clk); #1 cfg_wr = 1'b1; cfg_addr = a; cfg_range = r;
        @(posedge clk); #1 cfg_wr = 1'b0;
    endtask

    task automatic wait_valid(input int n0, input string req);
        int k = 0;
        while (got_valid == n0 && k < 600) begin
            @(negedge clk);
            k++;
        end
        check(got_valid > n0, req, "result arrived", got_valid - n0, 1);
    endtask

    task automatic do_conv(input string req);
        int n0 = got_valid;
        pulse_start();
        wait_valid(n0, req);
    endtask

    initial begin
        logic [1:0] exp_range;
        logic       exp_addr;
        void'($urandom(32'h5eed_0417));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(adc_cnv_n == 1'b1, "R10", "cnv_n after reset", adc_cnv_n, 1);
        check(adc_cs_n == 1'b1, "R10", "cs_n after reset", adc_cs_n, 1);
        check(adc_sclk == 1'b1, "R10", "sclk after reset", adc_sclk, 1);
        check(adc_range == 2'b00, "R10", "range after reset", adc_range, 0);
        check(adc_addr == 1'b0, "R10", "addr after reset", adc_addr, 0);
        check(smp_valid == 1'b0 && busy_err == 1'b0, "R10", "strobes after reset",
              {smp_valid, busy_err}, 0);

        // first conversion reports pair 0 even with the address pin at 1
        cfg_write(1'b1, 2'b01);
        repeat (4) @(negedge clk);
        check(adc_addr == 1'b1, "R7", "addr applied in idle", adc_addr, 1);
        check(adc_range == 2'b01, "R7", "range applied in idle", adc_range, 1);
        do_conv("R4");
        check(last_tag == 1'b0, "R4", "first tag after reset", last_tag, 0);
        do_conv("R4");
        check(last_tag == 1'b1, "R4", "tag one conversion late", last_tag, 1);

        // illegal range code is refused, address still taken
        cfg_write(1'b0, 2'b11);
        repeat (4) @(negedge clk);
        check(adc_range == 2'b01, "R5", "range kept on code 11", adc_range, 1);
        check(adc_addr == 1'b0, "R5", "addr taken with code 11", adc_addr, 0);
        cfg_write(1'b0, 2'b10);
        repeat (4) @(negedge clk);
        check(adc_range == 2'b10, "R5", "range 0 to 10 V", adc_range, 2);
        cfg_write(1'b1, 2'b11);
        repeat (4) @(negedge clk);
        check(adc_range == 2'b10, "R5", "range kept again", adc_range, 2);
        exp_range = 2'b10;
        exp_addr  = 1'b1;

        // sign extension extremes
        use_fixed = 1'b1;
        fix_a = {1'b1, {(DW-1){1'b0}}};
        fix_b = {1'b0, {(DW-1){1'b1}}};
        do_conv("R3");
        check(smp_a == 16'hE000, "R3", "most negative word", smp_a, 16'hE000);
        check(smp_b == 16'h1FFF, "R3", "largest positive word", smp_b, 16'h1FFF);
        use_fixed = 1'b0;

        // random mix: writes in idle and writes while busy is high
        for (int it = 0; it < 40; it++) begin
            logic       a = 1'($urandom);
            logic [1:0] r = 2'($urandom);
            int         n0;
            if (r != 2'b11) exp_range = r;
            exp_addr = a;
            if ($urandom % 2) begin
                cfg_write(a, r);
                repeat (3) @(negedge clk);
                do_conv("R2");
            end else begin
                int k = 0;
                n0 = got_valid;
                pulse_start();
                while (!adc_busy && k < 60) begin
                    @(negedge clk);
                    k++;
                end
                cfg_write(a, r);
                wait_valid(n0, "R7");
            end
            repeat (2 + $urandom % 6) @(negedge clk);
            check(adc_range == exp_range, "R5", "range pins", adc_range, exp_range);
            check(adc_addr == exp_addr, "R7", "addr pin", adc_addr, exp_addr);
        end

        // busy never rises
        begin
            int e0 = err_seen;
            int k = 0;
            hang = 1'b1;
            pulse_start();
            while (err_seen == e0 && k < TMO + 40) begin
                @(negedge clk);
                k++;
            end
            check(err_seen == e0 + 1, "R8", "timeout pulse", err_seen - e0, 1);
            check(adc_cnv_n && adc_cs_n, "R8", "lines high after timeout",
                  {adc_cnv_n, adc_cs_n}, 3);
            hang = 1'b0;
            repeat (4) @(negedge clk);
            do_conv("R8");
        end

        // periodic conversions
        begin
            int f0;
            int k = 0;
            rate_period = RW'(RATE_P);
            have_prev = 1'b0;
            rate_chk = 1'b1;
            f0 = cnv_falls;
            @(posedge clk); #1 rate_en = 1'b1;
            while (cnv_falls < f0 + 6 && k < 2000) begin
                @(negedge clk);
                k++;
            end
            @(posedge clk); #1 rate_en = 1'b0;
            rate_chk = 1'b0;
            check(cnv_falls >= f0 + 6, "R9", "timer conversions", cnv_falls - f0, 6);
            repeat (200) @(negedge clk);
        end

        finish_run();
    end

endmodule